// File: doc/BRIEF.md
# Byte-Serial Word Exchange Register

This block holds one word of storage that is reached only through two byte-wide
channels, one inbound and one outbound. A pulse of the inbound valid strobe starts a
transaction. The block then takes four bytes on four back-to-back clock edges,
lowest byte first, and builds a word from them. It then exchanges that word with the
stored word. One cycle copies the old contents into a holding register, and the
following cycle writes the new word into storage. After that the old contents leave
on the outbound channel, one byte per cycle, lowest byte first, while the outbound
valid strobe is high.

Every write therefore returns the value it replaced, with a fixed delay. The block
suits a host that wants an atomic swap over a narrow link. The host must not start a
second exchange until the outbound stream has ended. Any strobe it presents before
then is disregarded.

The controller has five states:
- `ST_IDLE`: waiting for the inbound strobe.
- `ST_COLLECT`: taking bytes 1 to 3.
- `ST_READ`: copying the old word.
- `ST_WRITE`: committing the new word.
- `ST_EMIT`: sending four bytes.

It has five transitions:
- `T_START` (IDLE to COLLECT): the strobe is seen, and byte 0 is taken on the same edge.
- `T_FULL` (COLLECT to READ): the lane count reaches 3.
- `T_COPY` (READ to WRITE): unconditional.
- `T_COMMIT` (WRITE to EMIT): unconditional; the lane count is cleared.
- `T_DONE` (EMIT to IDLE): the lane count reaches 3.

Top module: `serial_xchg_reg`

## Requirements
- R1: While idle with `in_vld` low, `busy` and `out_vld` stay low, and nothing is stored or emitted.
- R2: A transaction starts on the rising edge where `in_vld` is high in the idle state. That edge and the next three take `in_byte` as bytes 0 to 3, and byte i lands in bits [8i+7:8i] of the new word.
- R3: The word held before the transaction is the word emitted. The new word replaces it. The first output byte appears in the cycle that follows the second rising edge after the edge that took byte 3.
- R4: `out_vld` is high for exactly four consecutive cycles per transaction. During them `out_byte` carries bits [7:0], [15:8], [23:16] and [31:24] of the old word, in that order.
- R5: `out_byte` is zero in every cycle in which `out_vld` is low.
- R6: The stored word is zero after reset, so the first transaction emits 0x00000000.
- R7: `in_vld` and `in_byte` are ignored from the edge after byte 3 is taken until `out_vld` has fell. Data presented then reaches neither the output nor storage.
- R8: `busy` is high from the cycle after the edge that took byte 0 through the cycle of the last output byte, and low otherwise.
- R9: A new transaction may start on the first rising edge after `out_vld` falls, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Inbound strobe; starts a transaction when idle |
| in_byte | input | 8 | Inbound data byte |
| out_vld | output | 1 | High while an old-word byte is on `out_byte` |
| out_byte | output | 8 | Outbound data byte; zero when `out_vld` is low |
| busy | output | 1 | High while a transaction is in flight |

## Verification
Several properties are checked on every cycle:
- `out_byte` is quiet whenever `out_vld` is low.
- `out_vld` always runs at least four cycles.
- The rise of `out_vld` sits exactly five edges after `busy` rose.
- `busy` can only rise from a sampled `in_vld`.
- Storage is frozen outside the write cycle.

Only the bench's scenarios can show that the right bytes come out in the right lane order. They also show that each exchange returns exactly the previous word, including the zero left by reset. Further, they show that traffic sent during a transaction never leaks into later results, and that back-to-back and gapped transactions behave alike. The bench sweeps a walking one across all 32 bits and a spread of dense patterns against an arithmetic model of the storage.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_COLLECT = 3'd1,
        ST_READ    = 3'd2,
        ST_WRITE   = 3'd3,
        ST_EMIT    = 3'd4
    } xchg_state_e;

endpackage

// File: rtl/xchg_ctrl.sv
module xchg_ctrl
    import xchg_pkg::*;
#(
    parameter int NLANES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_vld,
    output logic                        cap_en,
    output logic                        cap_first,
    output logic [$clog2(NLANES)-1:0]   cap_lane,
    output logic                        rd_en,
    output logic                        wr_en,
    output logic                        emit_en,
    output logic [$clog2(NLANES)-1:0]   emit_lane,
    output logic                        busy
);
    localparam int LANE_W = $clog2(NLANES);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NLANES - 1);
    localparam logic [LANE_W-1:0] ONE_LANE  = LANE_W'(1);

    xchg_state_e       state_q, state_d;
    logic [LANE_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_vld) begin              // T_START
                    state_d = ST_COLLECT;
                    cnt_d   = ONE_LANE;
                end
            end
            ST_COLLECT: begin
                if (cnt_q == LAST_LANE) begin  // T_FULL
                    state_d = ST_READ;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + ONE_LANE;
                end
            end
            ST_READ: begin                     // T_COPY
                state_d = ST_WRITE;
            end
            ST_WRITE: begin                    // T_COMMIT
                state_d = ST_EMIT;
                cnt_d   = '0;
            end
            ST_EMIT: begin
                if (cnt_q == LAST_LANE) begin  // T_DONE
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + ONE_LANE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        cap_en    = 1'b0;
        cap_first = 1'b0;
        cap_lane  = '0;
        rd_en     = 1'b0;
        wr_en     = 1'b0;
        emit_en   = 1'b0;
        emit_lane = cnt_q;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                cap_en    = in_vld;
                cap_first = 1'b1;
                busy      = 1'b0;
            end
            ST_COLLECT: begin
                cap_en   = 1'b1;
                cap_lane = cnt_q;
            end
            ST_READ:  rd_en   = 1'b1;
            ST_WRITE: wr_en   = 1'b1;
            ST_EMIT:  emit_en = 1'b1;
            default:  busy    = 1'b0;
        endcase
    end

    // R2: a transaction only begins from a sampled inbound strobe
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(in_vld));

    // R3: the write is always followed by the emit phase
    p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> emit_en);

    // R8: the collect phase lasts the full lane count before the read
    p_read_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> $past(cap_en) && $past(cap_en, 2) && $past(cap_en, 3));

endmodule

// File: rtl/xchg_collect.sv
module xchg_collect #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cap_en,
    input  logic                                 cap_first,
    input  logic [$clog2(DATA_W/BYTE_W)-1:0]     cap_lane,
    input  logic [BYTE_W-1:0]                    in_byte,
    output logic [DATA_W-1:0]                    word_o
);
    localparam int NLANES = DATA_W / BYTE_W;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (cap_en) begin
                if (cap_first) begin
                    // a fresh transaction clears the whole word; lane 0 takes the byte
                    lane_q <= (g == 0) ? in_byte : '0;
                end else if (cap_lane == g) begin
                    lane_q <= in_byte;
                end
            end
        end
        assign word_o[g*BYTE_W +: BYTE_W] = lane_q;
    end

endmodule

// File: rtl/xchg_store.sv
module xchg_store #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_tmp,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] new_word,
    output logic [DATA_W-1:0] old_word
);
    logic [DATA_W-1:0] store_q;
    logic [DATA_W-1:0] tmp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     store_q <= '0;
        else if (wr_en) store_q <= new_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tmp_q <= '0;
        else if (clr_tmp) tmp_q <= '0;
        else if (rd_en)   tmp_q <= store_q;
    end

    assign old_word = tmp_q;

    // R7: storage changes only in the write cycle
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(store_q));

    // R3: the read and the write never share a cycle
    p_split_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

endmodule

// File: rtl/xchg_emit.sv
module xchg_emit #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic                              emit_en,
    input  logic [$clog2(DATA_W/BYTE_W)-1:0]  emit_lane,
    input  logic [DATA_W-1:0]                 old_word,
    output logic [BYTE_W-1:0]                 out_byte
);
    localparam int NLANES = DATA_W / BYTE_W;

    logic [BYTE_W-1:0] lanes [NLANES];

    for (genvar g = 0; g < NLANES; g++) begin : g_split
        assign lanes[g] = old_word[g*BYTE_W +: BYTE_W];
    end

    assign out_byte = emit_en ? lanes[emit_lane] : '0;

endmodule

// File: rtl/serial_xchg_reg.sv
module serial_xchg_reg #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              out_vld,
    output logic [BYTE_W-1:0] out_byte,
    output logic              busy
);
    localparam int NLANES = DATA_W / BYTE_W;
    localparam int LANE_W = $clog2(NLANES);

    logic              cap_en, cap_first, rd_en, wr_en, emit_en;
    logic [LANE_W-1:0] cap_lane, emit_lane;
    logic [DATA_W-1:0] new_word, old_word;

    xchg_ctrl #(.NLANES(NLANES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (in_vld),
        .cap_en    (cap_en),
        .cap_first (cap_first),
        .cap_lane  (cap_lane),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .emit_en   (emit_en),
        .emit_lane (emit_lane),
        .busy      (busy)
    );

    xchg_collect #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .cap_first (cap_first),
        .cap_lane  (cap_lane),
        .in_byte   (in_byte),
        .word_o    (new_word)
    );

    xchg_store #(.DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_tmp   (cap_en && cap_first),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .new_word  (new_word),
        .old_word  (old_word)
    );

    xchg_emit #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_emit (
        .emit_en   (emit_en),
        .emit_lane (emit_lane),
        .old_word  (old_word),
        .out_byte  (out_byte)
    );

    assign out_vld = emit_en;

    // R5: a quiet output byte outside the valid window
    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (out_byte == '0));

    // R4: a valid burst is never shorter than four cycles
    p_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_vld) |-> $past(out_vld, 2) && $past(out_vld, 3) && $past(out_vld, 4));

    // R3: fixed distance from the start of a transaction to the first output byte
    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_vld) |-> $past(busy, 5) && !$past(busy, 6));

    // R8: output only during a busy transaction
    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> busy);

endmodule

// File: tb/sim_serial_xchg_reg.sv
module sim_serial_xchg_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_vld = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_vld;
    logic [7:0] out_byte;
    logic       busy;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [31:0] model_store = 32'h0;

    always #5 clk = ~clk;

    serial_xchg_reg u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte),
        .out_vld(out_vld), .out_byte(out_byte), .busy(busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // caller is at a negedge; returns at the negedge where the block is idle again
    task automatic exchange(input logic [31:0] w, input bit junk);
        logic [31:0] exp_old = model_store;
        in_vld  = 1'b1;
        in_byte = w[7:0];
        for (int i = 1; i < 4; i++) begin
            @(negedge clk);
            check("R8 busy in collect", {31'b0, busy}, 32'd1);
            check("R5 quiet in collect", {23'b0, out_vld, out_byte}, 32'd0);
            in_vld  = junk;
            in_byte = w[8*i +: 8];
        end
        // R7: junk presented from here on must be ignored
        @(negedge clk);
        in_byte = ~w[7:0];
        check("R3 no output in read", {31'b0, out_vld}, 32'd0);
        @(negedge clk);
        in_byte = 8'h5A;
        check("R3 no output in write", {31'b0, out_vld}, 32'd0);
        check("R8 busy in write", {31'b0, busy}, 32'd1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R3 out_vld window", {31'b0, out_vld}, 32'd1);
            check("R4 old byte lane", {24'b0, out_byte}, {24'b0, exp_old[8*i +: 8]});
            check("R8 busy in emit", {31'b0, busy}, 32'd1);
            in_byte = w[31:24] ^ 8'(i);
        end
        @(negedge clk);
        in_vld = 1'b0;
        check("R4 out_vld falls after four", {31'b0, out_vld}, 32'd0);
        check("R5 quiet after emit", {24'b0, out_byte}, 32'd0);
        check("R8 busy low after", {31'b0, busy}, 32'd0);
        model_store = w;
    endtask

    task automatic idle_gap(input int n);
        for (int k = 0; k < n; k++) begin
            in_vld  = 1'b0;
            in_byte = 8'(8'hC3 + k);
            @(negedge clk);
            check("R1 idle busy", {31'b0, busy}, 32'd0);
            check("R1 idle out", {23'b0, out_vld, out_byte}, 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset busy", {31'b0, busy}, 32'd0);
        check("R5 reset out", {23'b0, out_vld, out_byte}, 32'd0);
        rst_n = 1'b1;
        idle_gap(3);
        // R6: first exchange returns the reset value of zero
        exchange(32'h8765_4321, 1'b1);
        // R2/R4: walking one over every bit, back-to-back (R9)
        for (int b = 0; b < 32; b++) exchange(32'h1 << b, b[0]);
        idle_gap(2);
        exchange(32'hFFFF_FFFF, 1'b1);
        exchange(32'h0000_0000, 1'b0);
        // dense arithmetic patterns, gaps on every third (R1, R9)
        for (int k = 1; k <= 24; k++) begin
            exchange(32'(k) * 32'h9E37_79B9 ^ 32'(k << 20), k[1]);
            if (k % 3 == 0) idle_gap(1);
        end
        exchange(32'h0, 1'b1);  // returns the last pattern (R7 store not disturbed)
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule